// File: doc/BRIEF.md
# Slotted Transmit and Acknowledge Retry Controller

This block is the terminal-side controller for a slotted, bufferless switching network. The network gives no grant and holds no buffer. A terminal holds one pending message and launches it at the start of a slot without asking first. The fabric either routes the message or drops it. If the message reaches its destination, that terminal sends back a short acknowledgement pulse along the same path, and the pulse arrives before the slot ends. If the source sees that pulse in time, the message is retired. If it does not, the source sends the same message again in the next slot.

Time is divided into slots of `SLOT_LEN` clock cycles, and all terminals share one reset so that their slot boundaries line up. While a message is in flight, the controller drives the frame bit and the destination address for the whole slot. The payload lanes stay quiet for the first `GUARD_LEN` cycles so that switches can settle and receivers can recover their clocks. The acknowledgement window closes `ACK_CLOSE` cycles before the slot boundary. A retry limit turns a message that is never acknowledged into a reported failure, and the message is then dropped.

The same block also holds the receive side. When a framed message addressed to this terminal starts arriving, it returns a one-cycle acknowledgement pulse.

Top module: `slot_tx_retry`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `host_ready` is 1 and `tx_frame`, `tx_addr`, `tx_pay_en`, `tx_data`, `done_ok`, `done_fail` and `ack_out` are all 0.
- R2: A message (`host_dest`, `host_data`) is taken on a clock edge where `host_valid` and `host_ready` are both 1. `host_ready` is 0 from that edge until the message is retired or dropped. While it is 0, `host_valid` and the host fields have no effect on what is later sent.
- R3: The slot phase is 0 during reset and advances by one on each clock edge, wrapping after `SLOT_LEN` cycles. A message accepted in any phase starts sending in the next phase-0 cycle, with no request or grant.
- R4: While sending, `tx_frame` is 1 and `tx_addr` holds the destination for all `SLOT_LEN` cycles of the slot, and both return to 0 together at the slot boundary unless the message is sent again.
- R5: Within a sending slot, `tx_pay_en` is 0 and `tx_data` is 0 in phases below `GUARD_LEN`. From phase `GUARD_LEN` to the end of the slot, `tx_pay_en` is 1 and `tx_data` carries the message.
- R6: An `ack_in` pulse in phases 0 to `SLOT_LEN-ACK_CLOSE-1` of a sending slot retires the message. `done_ok` is then 1 for exactly the phase-0 cycle of the next slot, `host_ready` is 1 in that cycle, and nothing is sent in that slot.
- R7: If a sending slot ends with no `ack_in` inside its window (including a pulse in the last `ACK_CLOSE` phases), the same message is sent again in the next slot.
- R8: A message is sent at most `MAX_RETRY+1` times. After the last unacknowledged attempt, `done_fail` is 1 for the phase-0 cycle that follows, the message is dropped, and `host_ready` returns to 1.
- R9: `ack_in` has no effect in a slot in which nothing is being sent.
- R10: `ack_out` is 1 for exactly one cycle, the cycle after a clock edge at which `rx_frame` is first seen high (it was low at the previous edge) while `rx_addr` equals `my_addr`. A frame carrying any other address produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, shared by all terminals |
| host_valid | input | 1 | Host offers a message |
| host_ready | output | 1 | No message pending; the offer is taken |
| host_dest | input | AW | Destination address of the offered message |
| host_data | input | DW | Payload word of the offered message |
| done_ok | output | 1 | One-cycle pulse: the message was acknowledged |
| done_fail | output | 1 | One-cycle pulse: retry limit reached, message dropped |
| tx_frame | output | 1 | Frame bit, high for the whole sending slot |
| tx_addr | output | AW | Routing address bits, held for the whole slot |
| tx_pay_en | output | 1 | Payload phase, after the guard interval |
| tx_data | output | DW | Payload word, 0 outside the payload phase |
| ack_in | input | 1 | Acknowledgement pulse returning from the network |
| my_addr | input | AW | This terminal's own address |
| rx_frame | input | 1 | Frame bit of an arriving message |
| rx_addr | input | AW | Address bits of an arriving message |
| ack_out | output | 1 | Acknowledgement pulse sent back for an arriving message |

## Verification
A slot phase counter that is off by even one cycle moves the rising edge of `tx_frame` and the start of `tx_pay_en`. The per-cycle comparison catches this in the first slot that sends. A wrong acknowledgement flag or a wrong window bound shows up at the next slot boundary as a swapped `done_ok` or as a repeated frame. A wrong retry count only becomes visible as an early or late `done_fail`, up to `MAX_RETRY+1` slots after the message was accepted. The scenarios therefore place acknowledgements on the last open phase and on the first closed phase, and they run one message all the way to its limit.

// File: rtl/slot_tx_retry.sv
module slot_tx_retry #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int SLOT_LEN  = 16,
  parameter int GUARD_LEN = 3,
  parameter int ACK_CLOSE = 2,
  parameter int MAX_RETRY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic [AW-1:0] host_dest,
  input  logic [DW-1:0] host_data,
  output logic          done_ok,
  output logic          done_fail,
  output logic          tx_frame,
  output logic [AW-1:0] tx_addr,
  output logic          tx_pay_en,
  output logic [DW-1:0] tx_data,
  input  logic          ack_in,
  input  logic [AW-1:0] my_addr,
  input  logic          rx_frame,
  input  logic [AW-1:0] rx_addr,
  output logic          ack_out
);
  localparam int CW = $clog2(SLOT_LEN);
  localparam int RW = $clog2(MAX_RETRY + 2);
  localparam logic [CW-1:0] LAST    = CW'(SLOT_LEN - 1);
  localparam logic [CW-1:0] WIN_END = CW'(SLOT_LEN - ACK_CLOSE);
  localparam logic [CW-1:0] GUARD   = CW'(GUARD_LEN);
  localparam logic [RW-1:0] LIMIT   = RW'(MAX_RETRY);

  logic [CW-1:0] phase;
  logic          pend, pend_n, tx_on, got_ack, rx_q;
  logic [AW-1:0] dest;
  logic [DW-1:0] data;
  logic [RW-1:0] tries;

  wire wrap    = phase == LAST;
  wire closing = wrap && tx_on;
  wire give_up = tries == LIMIT;
  wire take    = host_valid && !pend;

  assign host_ready = !pend;
  assign tx_frame   = tx_on;
  assign tx_addr    = tx_on ? dest : '0;
  assign tx_pay_en  = tx_on && (phase >= GUARD);
  assign tx_data    = tx_pay_en ? data : '0;

  always_comb begin
    pend_n = pend;
    if (closing && (got_ack || give_up)) pend_n = 1'b0;
    if (take) pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      pend      <= 1'b0;
      tx_on     <= 1'b0;
      got_ack   <= 1'b0;
      dest      <= '0;
      data      <= '0;
      tries     <= '0;
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
      rx_q      <= 1'b0;
      ack_out   <= 1'b0;
    end else begin
      phase     <= wrap ? '0 : phase + 1'b1;
      pend      <= pend_n;
      done_ok   <= closing && got_ack;
      done_fail <= closing && !got_ack && give_up;
      if (take) begin
        dest  <= host_dest;
        data  <= host_data;
        tries <= '0;
      end else if (closing && !got_ack && !give_up) begin
        tries <= tries + 1'b1;
      end
      if (wrap) begin
        tx_on   <= pend_n;
        got_ack <= 1'b0;
      end else if (tx_on && ack_in && phase < WIN_END) begin
        got_ack <= 1'b1;
      end
      rx_q    <= rx_frame;
      ack_out <= rx_frame && !rx_q && (rx_addr == my_addr);
    end
  end

  // R3
  frame_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_frame) |-> phase == '0);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame && phase != '0) |-> $stable(tx_addr));
  // R5
  guard_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_frame) |-> !tx_pay_en);
  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame |-> !host_ready);
  // R6
  ok_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> host_ready && !done_fail);
  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= LIMIT);
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> !ack_out);
endmodule

// File: tb/test_slot_tx_retry.sv
module test_slot_tx_retry;
  localparam int AW = 3, DW = 8, SLOT = 16, GUARD = 3, CLOSE = 2, MAXR = 2;
  localparam logic [AW-1:0] MY = 3'd4;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, ack_in = 0, rx_frame = 0;
  logic [AW-1:0] host_dest = 0, rx_addr = 0;
  logic [DW-1:0] host_data = 0;
  logic host_ready, done_ok, done_fail, tx_frame, tx_pay_en, ack_out;
  logic [AW-1:0] tx_addr;
  logic [DW-1:0] tx_data;

  always #2 clk = ~clk;

  slot_tx_retry #(.AW(AW), .DW(DW), .SLOT_LEN(SLOT), .GUARD_LEN(GUARD),
                  .ACK_CLOSE(CLOSE), .MAX_RETRY(MAXR)) i_slot_tx_retry (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_dest(host_dest), .host_data(host_data), .done_ok(done_ok),
    .done_fail(done_fail), .tx_frame(tx_frame), .tx_addr(tx_addr),
    .tx_pay_en(tx_pay_en), .tx_data(tx_data), .ack_in(ack_in),
    .my_addr(MY), .rx_frame(rx_frame), .rx_addr(rx_addr), .ack_out(ack_out));

  int checks = 0, errors = 0, ack_seen = 0;
  int m_cnt, m_tries;
  bit m_pend, m_txon, m_got, m_ok, m_fail, m_rxq, m_ack;
  bit t_last, t_close, t_succ, t_drop, t_pn, prev_frame;
  int m_dest, m_data;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pend = 0; m_txon = 0; m_got = 0; m_tries = 0;
      m_dest = 0; m_data = 0; m_ok = 0; m_fail = 0; m_rxq = 0; m_ack = 0;
    end else begin
      t_last  = (m_cnt == SLOT - 1);
      t_close = t_last && m_txon;
      t_succ  = t_close && m_got;
      t_drop  = t_close && !m_got && m_tries == MAXR;
      m_ok = t_succ; m_fail = t_drop;
      t_pn = m_pend;
      if (t_succ || t_drop) t_pn = 0;
      if (t_close && !m_got && m_tries != MAXR) m_tries++;
      if (!m_pend && host_valid) begin
        t_pn = 1; m_dest = host_dest; m_data = host_data; m_tries = 0;
      end
      if (t_last) begin m_txon = t_pn; m_got = 0; end
      else if (m_txon && ack_in && m_cnt < SLOT - CLOSE) m_got = 1;
      m_pend = t_pn;
      m_ack = rx_frame && !m_rxq && (rx_addr == MY);
      m_rxq = rx_frame;
      m_cnt = t_last ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    bit pe;
    pe = m_txon && m_cnt >= GUARD;
    chk("R2 host_ready", host_ready, !m_pend);
    chk("R4 tx_frame", tx_frame, m_txon);
    chk("R4 tx_addr", tx_addr, m_txon ? m_dest : 0);
    chk("R5 tx_pay_en", tx_pay_en, pe);
    chk("R5 tx_data", tx_data, pe ? m_data : 0);
    chk("R6 done_ok", done_ok, m_ok);
    chk("R8 done_fail", done_fail, m_fail);
    chk("R10 ack_out", ack_out, m_ack);
    if (tx_frame && !prev_frame) chk("R3 frame starts at phase 0", m_cnt, 0);
    prev_frame = tx_frame;
    if (ack_out) ack_seen++;
  end

  task automatic go_to(int p);
    @(negedge clk);
    while (m_cnt != p) @(negedge clk);
  endtask

  task automatic offer(int d, int v);
    host_valid = 1; host_dest = AW'(d); host_data = DW'(v);
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic pulse_ack;
    ack_in = 1; @(negedge clk); ack_in = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int starts;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", host_ready, 1);
    chk("R1 reset frame", tx_frame, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {tx_frame, tx_pay_en, done_ok, done_fail, ack_out}, 0);

    // R9: stray acknowledgement while idle
    go_to(5); pulse_ack();
    go_to(0);
    chk("R9 idle ack no done", done_ok, 0);
    chk("R9 idle ack still ready", host_ready, 1);

    // R2/R6: accept, ignore later offers, ack in window
    go_to(2); offer(5, 8'hA5);
    host_valid = 1; host_dest = 3'd2; host_data = 8'h11;
    repeat (2) @(negedge clk);
    host_valid = 0;
    go_to(0);
    chk("R2 original dest kept", tx_addr, 5);
    go_to(6); pulse_ack();
    go_to(0);
    chk("R6 done_ok", done_ok, 1);
    chk("R6 not resent", tx_frame, 0);

    // R7: ack in closed window causes resend, then last open phase succeeds
    go_to(1); offer(3, 8'h3C);
    go_to(0); go_to(SLOT - CLOSE); pulse_ack();
    go_to(0);
    chk("R7 resent after late ack", tx_frame, 1);
    chk("R7 no done after late ack", done_ok, 0);
    go_to(SLOT - CLOSE - 1); pulse_ack();
    go_to(0);
    chk("R6 last open phase ack", done_ok, 1);

    // R8: never acknowledged
    go_to(4); offer(7, 8'h81);
    starts = 0;
    for (int k = 0; k < 5; k++) begin
      go_to(0);
      if (tx_frame) starts++;
      if (k == 3) chk("R8 fail pulse", done_fail, 1);
    end
    chk("R8 attempts", starts, MAXR + 1);
    chk("R8 ready after drop", host_ready, 1);

    // R3: accept in last phase, sent at once in next slot
    go_to(SLOT - 1); offer(1, 8'h5A);
    chk("R3 starts next phase", tx_frame, 1);
    go_to(4); pulse_ack();
    go_to(0);
    chk("R6 done after late accept", done_ok, 1);

    // R10: receive side
    ack_seen = 0;
    go_to(3);
    rx_frame = 1; rx_addr = MY;
    repeat (8) @(negedge clk);
    rx_frame = 0;
    repeat (2) @(negedge clk);
    rx_frame = 1; rx_addr = 3'd1;
    repeat (5) @(negedge clk);
    rx_frame = 0;
    repeat (3) @(negedge clk);
    chk("R10 single ack for own frame only", ack_seen, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule